// File: doc/BRIEF.md
# Coarse DC Offset Calibrator

This block strips the static DC offset from four signed ADC sample streams: the in-phase and quadrature paths of two receive channels. Because each analog path carries its own offset, every lane gets an independent estimate. A calibration request starts a measurement. The block then averages a fixed window of valid samples per lane, and the resulting offsets are latched together in a single cycle. Those frozen offsets are subtracted from every later sample until the next request. The corrected streams feed the gain-control stage that follows directly.

The averaging window is a power of two, so the mean is an arithmetic right shift of a wide accumulator and needs no divider. The expected offset is small compared with full scale, so each stored offset is a narrow signed word, and the estimate is clamped into that range. The subtraction saturates instead of wrapping. While a measurement is running, the output keeps flowing with the previous offsets applied.

The controller is a three-state machine:
- ST_IDLE waits for a start pulse.
- ST_ACCUM sums valid samples until the window is full.
- ST_LATCH is a single cycle in which the new offsets are captured.

It has three transitions:
- start accepted: ST_IDLE to ST_ACCUM, on cal_start with en high.
- window full: ST_ACCUM to ST_LATCH, on the last valid sample of the window.
- latch complete: ST_LATCH to ST_IDLE, unconditionally.

Lane order on the packed buses, counting from the least significant slice, is:
- lane 0: channel A in-phase
- lane 1: channel A quadrature
- lane 2: channel B in-phase
- lane 3: channel B quadrature

Top module: `coarse_dcc_top`

## Requirements
- R1: During and right after reset, out_vld and cal_done are 0, and out_data and all offsets are 0.
- R2: out_vld repeats in_vld one cycle later. For each valid sample with en high, out_data of each lane holds that lane's input minus its stored offset in the following cycle.
- R3: With en low, each lane of out_data holds the raw input sample one cycle later, and a cal_start pulse is ignored: no calibration follows and the offsets keep their values.
- R4: The window holds exactly 4096 valid samples per lane. Cycles with in_vld low are not counted. cal_done is high in the second cycle after the cycle that presents the 4096th valid sample.
- R5: Each lane's new offset is floor(sum/4096) of its own window samples, an arithmetic shift right by 12. For example, equal counts of -3 and -4 give -4.
- R6: The estimated offset is clamped to the signed 8-bit range [-128, 127] before it is stored.
- R7: The subtraction saturates to [-2048, 2047]; it never wraps.
- R8: Offsets change only in the cycle where cal_done is high, and they stay frozen otherwise.
- R9: A cal_start pulse while a calibration is running is ignored; the window keeps counting from the first accepted start.
- R10: cal_done is a one-cycle pulse, and all four offsets take their new values in that same cycle.
- R11: While a calibration runs, and in the cycle cal_done rises, the output is corrected with the previous offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Correction enable; low bypasses subtraction and blocks new starts |
| cal_start | input | 1 | Calibration request pulse |
| in_vld | input | 1 | Valid strobe shared by all four lanes |
| in_data | input | 48 | Four signed 12-bit samples, lane 0 in bits 11:0 |
| out_vld | output | 1 | Valid strobe for out_data |
| out_data | output | 48 | Four corrected signed 12-bit samples |
| ofs_out | output | 32 | Four stored signed 8-bit offsets, lane 0 in bits 7:0 |
| cal_done | output | 1 | One-cycle pulse when the offsets update |

## Verification
On every cycle, the checker confirms that the done flag lasts only one cycle and that the offsets stay frozen in every cycle without done. It also confirms that the output valid tracks the input valid with a one-cycle lag, and that the bypass path returns the raw sample when the enable is low. The bench scenarios show the behaviour that depends on whole windows of data:
- floor rounding of the mean for negative values;
- clamping of large means;
- saturation of the subtraction at both rails;
- the exact cycle of the done pulse with gaps in the valid strobe;
- start requests ignored in mid-window or while disabled;
- the previous offsets still applied during a measurement.

// File: rtl/coarse_dcc_pkg.sv
package coarse_dcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_LATCH = 2'd2
    } cal_state_t;

endpackage

// File: rtl/coarse_dcc_ctrl.sv
module coarse_dcc_ctrl
    import coarse_dcc_pkg::*;
#(
    parameter int WIN_LOG2 = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cal_start,
    input  logic in_vld,
    output logic clr_acc,
    output logic acc_en,
    output logic latch_ofs,
    output logic cal_done
);

    cal_state_t              state_q;
    cal_state_t              state_d;
    logic [WIN_LOG2-1:0]     cnt_q;
    logic                    window_full;

    // start is only accepted from idle and with correction enabled
    assign clr_acc     = (state_q == ST_IDLE) && en && cal_start;
    assign acc_en      = (state_q == ST_ACCUM) && in_vld;
    assign window_full = acc_en && (cnt_q == '1);
    assign latch_ofs   = (state_q == ST_LATCH);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (clr_acc)     state_d = ST_ACCUM;
            ST_ACCUM: if (window_full) state_d = ST_LATCH;
            ST_LATCH:                  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            cal_done <= 1'b0;
        end else begin
            if (clr_acc) begin
                cnt_q <= '0;
            end else if (acc_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            cal_done <= latch_ofs;
        end
    end

endmodule

// File: rtl/coarse_dcc_est.sv
module coarse_dcc_est #(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LOG2 = 12,
    parameter int OFS_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_acc,
    input  logic                       acc_en,
    input  logic                       latch_ofs,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic signed [OFS_W-1:0]    ofs
);

    localparam int ACC_W = SAMPLE_W + WIN_LOG2;
    localparam logic signed [ACC_W-1:0] LIM_HI = ACC_W'((1 << (OFS_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LIM_LO = ~LIM_HI;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] mean;
    logic signed [OFS_W-1:0] mean_clamped;

    // floor division by the window length
    assign mean = acc_q >>> WIN_LOG2;

    always_comb begin
        if (mean > LIM_HI) begin
            mean_clamped = LIM_HI[OFS_W-1:0];
        end else if (mean < LIM_LO) begin
            mean_clamped = LIM_LO[OFS_W-1:0];
        end else begin
            mean_clamped = mean[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ofs   <= '0;
        end else begin
            if (clr_acc) begin
                acc_q <= '0;
            end else if (acc_en) begin
                acc_q <= acc_q + ACC_W'(sample);
            end
            if (latch_ofs) begin
                ofs <= mean_clamped;
            end
        end
    end

endmodule

// File: rtl/coarse_dcc_sub.sv
module coarse_dcc_sub #(
    parameter int SAMPLE_W = 12,
    parameter int OFS_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [OFS_W-1:0]    ofs,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam int DIFF_W = SAMPLE_W + 1;
    localparam logic signed [SAMPLE_W-1:0] OUT_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] OUT_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [DIFF_W-1:0]   diff;
    logic signed [SAMPLE_W-1:0] diff_sat;

    assign diff = DIFF_W'(sample) - DIFF_W'(ofs);

    always_comb begin
        if (diff[DIFF_W-1] != diff[DIFF_W-2]) begin
            diff_sat = diff[DIFF_W-1] ? OUT_MIN : OUT_MAX;
        end else begin
            diff_sat = diff[SAMPLE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_vld) begin
            result <= en ? diff_sat : sample;
        end
    end

endmodule

// File: rtl/coarse_dcc_top.sv
module coarse_dcc_top #(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 12,
    parameter int WIN_LOG2 = 12,
    parameter int OFS_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      cal_start,
    input  logic                      in_vld,
    input  logic [LANES*SAMPLE_W-1:0] in_data,
    output logic                      out_vld,
    output logic [LANES*SAMPLE_W-1:0] out_data,
    output logic [LANES*OFS_W-1:0]    ofs_out,
    output logic                      cal_done
);

    logic clr_acc;
    logic acc_en;
    logic latch_ofs;

    coarse_dcc_ctrl #(
        .WIN_LOG2(WIN_LOG2)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cal_start(cal_start),
        .in_vld   (in_vld),
        .clr_acc  (clr_acc),
        .acc_en   (acc_en),
        .latch_ofs(latch_ofs),
        .cal_done (cal_done)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [SAMPLE_W-1:0] lane_in;
        logic signed [SAMPLE_W-1:0] lane_out;
        logic signed [OFS_W-1:0]    lane_ofs;

        assign lane_in = in_data[g*SAMPLE_W +: SAMPLE_W];

        coarse_dcc_est #(
            .SAMPLE_W(SAMPLE_W),
            .WIN_LOG2(WIN_LOG2),
            .OFS_W   (OFS_W)
        ) est_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_acc  (clr_acc),
            .acc_en   (acc_en),
            .latch_ofs(latch_ofs),
            .sample   (lane_in),
            .ofs      (lane_ofs)
        );

        coarse_dcc_sub #(
            .SAMPLE_W(SAMPLE_W),
            .OFS_W   (OFS_W)
        ) sub_i (
            .clk   (clk),
            .rst_n (rst_n),
            .in_vld(in_vld),
            .en    (en),
            .sample(lane_in),
            .ofs   (lane_ofs),
            .result(lane_out)
        );

        assign out_data[g*SAMPLE_W +: SAMPLE_W] = lane_out;
        assign ofs_out[g*OFS_W +: OFS_W]        = lane_ofs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
        end
    end

endmodule

// File: rtl/coarse_dcc_chk.sv
module coarse_dcc_chk #(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 12,
    parameter int OFS_W    = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      en,
    input logic                      in_vld,
    input logic [LANES*SAMPLE_W-1:0] in_data,
    input logic                      out_vld,
    input logic [LANES*SAMPLE_W-1:0] out_data,
    input logic [LANES*OFS_W-1:0]    ofs_out,
    input logic                      cal_done
);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

    // R8
    ofs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> $stable(ofs_out));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R3
    bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !en) |=> (out_data == $past(in_data)));

endmodule

bind coarse_dcc_top coarse_dcc_chk #(
    .LANES   (LANES),
    .SAMPLE_W(SAMPLE_W),
    .OFS_W   (OFS_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .in_vld  (in_vld),
    .in_data (in_data),
    .out_vld (out_vld),
    .out_data(out_data),
    .ofs_out (ofs_out),
    .cal_done(cal_done)
);

// File: tb/coarse_dcc_top_test.sv
module coarse_dcc_top_test;

    localparam int L  = 4;
    localparam int W  = 12;
    localparam int OW = 8;
    localparam int WIN = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic          cal_start = 1'b0;
    logic          in_vld = 1'b0;
    logic [L*W-1:0]  in_data = '0;
    logic          out_vld;
    logic [L*W-1:0]  out_data;
    logic [L*OW-1:0] ofs_out;
    logic          cal_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int va [L];
    int vb [L];
    int cur_ofs [L];

    always #10 clk = ~clk;

    coarse_dcc_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cal_start(cal_start),
        .in_vld   (in_vld),
        .in_data  (in_data),
        .out_vld  (out_vld),
        .out_data (out_data),
        .ofs_out  (ofs_out),
        .cal_done (cal_done)
    );

    function automatic int out_lane(input int i);
        return int'($signed(out_data[i*W +: W]));
    endfunction

    function automatic int ofs_lane(input int i);
        return int'($signed(ofs_out[i*OW +: OW]));
    endfunction

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic set_lanes(input int v0, input int v1, input int v2, input int v3);
        in_data[0*W +: W] = W'(v0);
        in_data[1*W +: W] = W'(v1);
        in_data[2*W +: W] = W'(v2);
        in_data[3*W +: W] = W'(v3);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        in_vld    = 1'b0;
        cal_start = 1'b1;
        @(negedge clk);
        cal_start = 1'b0;
    endtask

    // Feed one window of samples, alternating va/vb per lane.
    // gap_every > 0 inserts an idle cycle; restart_at pulses cal_start mid-window.
    task automatic run_window(input int gap_every, input int restart_at, input string req);
        int sent = 0;
        int cyc = 0;
        bit done_early = 0;
        while (sent < WIN) begin
            cyc++;
            if (gap_every > 0 && (cyc % gap_every) == 0) begin
                in_vld = 1'b0;
            end else begin
                in_vld = 1'b1;
                for (int i = 0; i < L; i++) in_data[i*W +: W] = W'((sent % 2 == 0) ? va[i] : vb[i]);
                cal_start = (sent == restart_at);
                sent++;
            end
            @(negedge clk);
            cal_start = 1'b0;
            if (cal_done) done_early = 1;
            // R11: output is corrected with previous offset during calibration
            if (in_vld && sent == WIN / 2)
                check("R11", "lane0 output mid-calibration", out_lane(0), sat12(va[0] - cur_ofs[0]));
        end
        // LATCH cycle: done not yet raised, old offsets still held
        check(req, "done not early", int'(done_early), 0);
        check("R4", "done low in latch cycle", int'(cal_done), 0);
        in_vld = 1'b1;
        set_lanes(100, 100, 100, 100);
        @(negedge clk);
        in_vld = 1'b0;
        check("R4", "done high second cycle after last sample", int'(cal_done), 1);
        check("R11", "lane0 output at done cycle uses old offset", out_lane(0), sat12(100 - cur_ofs[0]));
        @(negedge clk);
        check("R10", "done pulse lasts one cycle", int'(cal_done), 0);
    endtask

    task automatic check_ofs(input string req, input int e0, input int e1, input int e2, input int e3);
        check(req, "offset lane0", ofs_lane(0), e0);
        check(req, "offset lane1", ofs_lane(1), e1);
        check(req, "offset lane2", ofs_lane(2), e2);
        check(req, "offset lane3", ofs_lane(3), e3);
        cur_ofs[0] = e0; cur_ofs[1] = e1; cur_ofs[2] = e2; cur_ofs[3] = e3;
    endtask

    task automatic apply_and_check(input string req, input int v0, input int v1, input int v2, input int v3);
        @(negedge clk);
        in_vld = 1'b1;
        set_lanes(v0, v1, v2, v3);
        @(negedge clk);
        in_vld = 1'b0;
        check("R2", "out_vld follows in_vld", int'(out_vld), 1);
        check(req, "lane0 corrected", out_lane(0), en ? sat12(v0 - cur_ofs[0]) : v0);
        check(req, "lane1 corrected", out_lane(1), en ? sat12(v1 - cur_ofs[1]) : v1);
        check(req, "lane2 corrected", out_lane(2), en ? sat12(v2 - cur_ofs[2]) : v2);
        check(req, "lane3 corrected", out_lane(3), en ? sat12(v3 - cur_ofs[3]) : v3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_vld in reset", int'(out_vld), 0);
        check("R1", "cal_done in reset", int'(cal_done), 0);
        check("R1", "out_data in reset", int'(out_data != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "offsets after reset", int'(ofs_out != '0), 0);
        check("R1", "out_vld after reset", int'(out_vld), 0);
        for (int i = 0; i < L; i++) cur_ofs[i] = 0;
    endtask

    task automatic t_passthrough();
        apply_and_check("R2", 321, -7, 2047, -2048);
        @(negedge clk);
        check("R2", "out_vld low after idle", int'(out_vld), 0);
    endtask

    task automatic t_cal_floor();
        va[0] = 10;  vb[0] = 10;
        va[1] = -20; vb[1] = -20;
        va[2] = 3;   vb[2] = 4;
        va[3] = -3;  vb[3] = -4;
        pulse_start();
        run_window(0, -1, "R4");
        // R5: independent lanes, floor of mean
        check_ofs("R5", 10, -20, 3, -4);
        apply_and_check("R2", 100, -2048, 0, 2047);
    endtask

    task automatic t_cal_clamp_restart();
        va[0] = 500;   vb[0] = 500;
        va[1] = -1000; vb[1] = -1000;
        va[2] = 0;     vb[2] = 0;
        va[3] = 127;   vb[3] = 128;
        pulse_start();
        // gaps in valid (R4) and a start pulse at sample 100 (R9)
        run_window(7, 100, "R9");
        // R6: clamped to 8-bit signed range
        check_ofs("R6", 127, -128, 0, 127);
        // R7: saturation at both rails
        apply_and_check("R7", -2048, 2047, 5, 0);
        apply_and_check("R7", -1921, 1919, -2048, -2048);
    endtask

    task automatic t_hold();
        // R8: offsets stay frozen across many samples
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            in_vld = 1'b1;
            set_lanes(k * 9, -k, k, 3);
        end
        @(negedge clk);
        in_vld = 1'b0;
        check("R8", "offset lane0 held", ofs_lane(0), 127);
        check("R8", "offset lane1 held", ofs_lane(1), -128);
    endtask

    task automatic t_disabled();
        bit saw_done = 0;
        @(negedge clk);
        en = 1'b0;
        apply_and_check("R3", 400, -400, 7, -7);
        pulse_start();
        en = 1'b1;
        // feed more than a window; no calibration may complete
        for (int k = 0; k < WIN + 8; k++) begin
            in_vld = 1'b1;
            set_lanes(0, 0, 0, 0);
            @(negedge clk);
            if (cal_done) saw_done = 1;
        end
        in_vld = 1'b0;
        @(negedge clk);
        if (cal_done) saw_done = 1;
        check("R3", "start ignored while disabled", int'(saw_done), 0);
        check("R3", "offset lane0 unchanged", ofs_lane(0), 127);
        check("R3", "offset lane3 unchanged", ofs_lane(3), 127);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_passthrough();
        t_cal_floor();
        t_cal_clamp_restart();
        t_hold();
        t_disabled();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule